// File: doc/BRIEF.md
# Multi-Stage Timing Scaler with Standby Wake

This block turns one fast oscillator clock into every slow timing rate a system needs. A one-hot four-phase rotator produces the internal phase signals, and one of those phases yields the master-frequency enable used to keep external equipment in step. A self-correcting five-position ring counter divides the master rate by five. A parameterised chain of binary stages (seventeen by default) then halves the rate again and again. Every rate leaves the block as a one-cycle enable pulse in the oscillator domain, so nothing downstream needs a derived clock.

One stage (the tenth by default) issues increment requests to the real-time counters. The last stage drives a standby controller. While the standby-allowed input is high, the controller drops the power-enable output. The phases, the ring and the stage chain keep counting while power is off. Each tick of the last stage raises power for a fixed number of cycles. At the end of that hold window the standby input is sampled again: if it is still high the block goes back to sleep, otherwise normal operation resumes.

The controller has three states:
- `PS_RUN`: powered and running normally.
- `PS_SLEEP`: power-enable low.
- `PS_WAKE`: powered, counting down the hold window.

It has four transitions:
- standby entry, `PS_RUN`→`PS_SLEEP`.
- wake, `PS_SLEEP`→`PS_WAKE`.
- re-sleep, `PS_WAKE`→`PS_SLEEP`.
- resume, `PS_WAKE`→`PS_RUN`.

Top module: `timing_scaler`

## Requirements
- R1: After reset `phase` is 4'b0001. On every oscillator cycle the one-hot value rotates one place toward the most significant bit, with bit 3 wrapping back to bit 0.
- R2: `mstr_tick` is high for exactly one cycle in every four, namely in the cycle where `phase` is 4'b1000. Counting cycles n from reset release, with n=0 being the first cycle, this gives n mod 4 = 3.
- R3: `ring_tick` is high once every 20 cycles, first at cycle 19. It is driven by a five-position one-hot ring that resets to 5'b00001 and advances on each `mstr_tick`.
- R4: Bit k-1 of `stage_tick` (stage Fk, where k runs from 1 to N_STAGES) pulses with a period of 20·2^k cycles, first at cycle 20·2^k − 1.
- R5: `inc_req` equals the pulse of stage F(INC_STAGE) while `power_en` is high, and stays low in `PS_SLEEP`.
- R6: After reset the block is in `PS_RUN` with `power_en` high. In `PS_RUN`, `stby_allow` high at a clock edge moves the block to `PS_SLEEP`, where `power_en` is low.
- R7: In `PS_SLEEP`, a pulse of the last stage raises `wake_pulse` in that same cycle. From the next cycle, `power_en` is high for exactly WAKE_HOLD cycles in `PS_WAKE`.
- R8: On the last cycle of the hold window, `stby_allow` high returns the block to `PS_SLEEP`; otherwise it goes to `PS_RUN`.
- R9: The phase, ring and stage outputs follow R1–R4 exactly, whatever the standby state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_allow | input | 1 | Standby permitted |
| phase | output | 4 | One-hot four-phase timing vector |
| mstr_tick | output | 1 | Master-frequency enable pulse |
| ring_tick | output | 1 | Divide-by-five enable pulse |
| stage_tick | output | N_STAGES | Per-stage enable pulses, bit k-1 = Fk |
| inc_req | output | 1 | Real-time counter increment request |
| wake_pulse | output | 1 | Standby wake event |
| power_en | output | 1 | Power-enable for gated logic |

## Verification
On every cycle, the assertions check the phase rotation and the one-hot condition of the ring. They also check that increment requests never appear with power off, that a wake event is always followed by power, and that power only falls after standby was allowed. Exact tick periods and first-tick positions of the stages, the length of the hold window, and the sleep-or-resume decision under changing `stby_allow` can only be shown by the bench's scenarios. These cover directed waits across wake events and random standby patterns compared against a cycle-count model.

// File: rtl/tscl_pkg.sv
package tscl_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_SLEEP = 2'd1,
        PS_WAKE  = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/tscl_phase.sv
module tscl_phase (
    input  logic       clk,
    input  logic       rst,
    output logic [3:0] phase,
    output logic       mstr_tick
);
    logic [3:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 4'b0001;
        else     phase_q <= {phase_q[2:0], phase_q[3]};
    end

    always_comb begin
        phase     = phase_q;
        mstr_tick = phase_q[3];
    end
endmodule

// File: rtl/tscl_ring.sv
module tscl_ring #(
    parameter int RING_LEN = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    output logic [RING_LEN-1:0] ring_state,
    output logic                ring_tick
);
    logic [RING_LEN-1:0] ring_q;

    // Shifting in a one only when the lower bits are all zero pulls any
    // corrupted pattern back to a single hot bit.
    always_ff @(posedge clk) begin
        if (rst)      ring_q <= {{(RING_LEN-1){1'b0}}, 1'b1};
        else if (adv) ring_q <= {ring_q[RING_LEN-2:0], ~|ring_q[RING_LEN-2:0]};
    end

    always_comb begin
        ring_state = ring_q;
        ring_tick  = adv & ring_q[RING_LEN-1];
    end
endmodule

// File: rtl/tscl_chain.sv
module tscl_chain #(
    parameter int N_STAGES = 17
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                carry_in,
    output logic [N_STAGES-1:0] stage_tick
);
    logic [N_STAGES-1:0] tgl_q;
    logic [N_STAGES:0]   carry;

    assign carry[0] = carry_in;

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)           tgl_q[k] <= 1'b0;
            else if (carry[k]) tgl_q[k] <= ~tgl_q[k];
        end
        assign carry[k+1]    = carry[k] & tgl_q[k];
        assign stage_tick[k] = carry[k+1];
    end
endmodule

// File: rtl/tscl_standby.sv
module tscl_standby
    import tscl_pkg::*;
#(
    parameter int WAKE_HOLD = 8,
    localparam int HW = $clog2(WAKE_HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic stby_allow,
    input  logic last_tick,
    input  logic inc_tick,
    output logic power_en,
    output logic wake_pulse,
    output logic inc_req
);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(WAKE_HOLD - 1);

    pwr_state_t    state_q, state_d;
    logic [HW-1:0] hold_q, hold_d;

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            PS_RUN: begin
                if (stby_allow) state_d = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (last_tick) begin
                    state_d = PS_WAKE;
                    hold_d  = HOLD_LOAD;
                end
            end
            PS_WAKE: begin
                if (hold_q == '0) state_d = stby_allow ? PS_SLEEP : PS_RUN;
                else              hold_d  = hold_q - 1'b1;
            end
            default: state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_RUN;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        power_en   = 1'b1;
        wake_pulse = 1'b0;
        inc_req    = inc_tick;
        unique case (state_q)
            PS_SLEEP: begin
                power_en   = 1'b0;
                wake_pulse = last_tick;
                inc_req    = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/timing_scaler.sv
module timing_scaler #(
    parameter int N_STAGES  = 17,
    parameter int INC_STAGE = 10,
    parameter int WAKE_HOLD = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stby_allow,
    output logic [3:0]          phase,
    output logic                mstr_tick,
    output logic                ring_tick,
    output logic [N_STAGES-1:0] stage_tick,
    output logic                inc_req,
    output logic                wake_pulse,
    output logic                power_en
);
    localparam int RING_LEN = 5;
    localparam int INC_IDX  = INC_STAGE - 1;

    logic [RING_LEN-1:0] ring_state;

    tscl_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .mstr_tick (mstr_tick)
    );

    tscl_ring #(.RING_LEN(RING_LEN)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .adv        (mstr_tick),
        .ring_state (ring_state),
        .ring_tick  (ring_tick)
    );

    tscl_chain #(.N_STAGES(N_STAGES)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .carry_in   (ring_tick),
        .stage_tick (stage_tick)
    );

    tscl_standby #(.WAKE_HOLD(WAKE_HOLD)) u_stby (
        .clk        (clk),
        .rst        (rst),
        .stby_allow (stby_allow),
        .last_tick  (stage_tick[N_STAGES-1]),
        .inc_tick   (stage_tick[INC_IDX]),
        .power_en   (power_en),
        .wake_pulse (wake_pulse),
        .inc_req    (inc_req)
    );
endmodule

// File: rtl/timing_scaler_chk.sv
module timing_scaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       stby_allow,
    input logic [3:0] phase,
    input logic [4:0] ring_state,
    input logic       inc_req,
    input logic       wake_pulse,
    input logic       power_en
);
    assert_phase_rotate_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == {$past(phase[2:0]), $past(phase[3])});

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase));

    assert_ring_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot(ring_state));

    assert_inc_powered_R5: assert property (@(posedge clk) disable iff (rst)
        inc_req |-> power_en);

    assert_power_drop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(power_en) |-> $past(stby_allow));

    assert_wake_power_R7: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> power_en);

    assert_wake_from_sleep_R7: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !power_en);
endmodule

bind timing_scaler timing_scaler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .stby_allow (stby_allow),
    .phase      (phase),
    .ring_state (ring_state),
    .inc_req    (inc_req),
    .wake_pulse (wake_pulse),
    .power_en   (power_en)
);

// File: tb/timing_scaler_bench.sv
module timing_scaler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 6;
    localparam int INC  = 3;
    localparam int HOLD = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stby_allow = 1'b0;
    logic [3:0]    phase;
    logic          mstr_tick, ring_tick, inc_req, wake_pulse, power_en;
    logic [NS-1:0] stage_tick;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model: 0 run, 1 sleep, 2 wake
    int n = 0;
    int m_state = 0;
    int m_hold = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timing_scaler #(.N_STAGES(NS), .INC_STAGE(INC), .WAKE_HOLD(HOLD)) u_timing_scaler (
        .clk        (clk),
        .rst        (rst),
        .stby_allow (stby_allow),
        .phase      (phase),
        .mstr_tick  (mstr_tick),
        .ring_tick  (ring_tick),
        .stage_tick (stage_tick),
        .inc_req    (inc_req),
        .wake_pulse (wake_pulse),
        .power_en   (power_en)
    );

    function automatic bit tick_at(int cyc, int period);
        return ((cyc + 1) % period) == 0;
    endfunction

    function automatic logic [NS-1:0] exp_stages(int cyc);
        logic [NS-1:0] v;
        for (int k = 1; k <= NS; k++) v[k-1] = tick_at(cyc, 20 * (1 << k));
        return v;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, n, act, exp);
        end
    endtask

    // compare all outputs against the model for cycle n
    task automatic check_cycle();
        logic [NS-1:0] es;
        bit last, pw;
        es   = exp_stages(n);
        last = es[NS-1];
        pw   = (m_state != 1);
        check(phase == 4'(1 << (n % 4)), "R1", phase, 4'(1 << (n % 4)));
        check(mstr_tick == tick_at(n, 4), "R2", mstr_tick, tick_at(n, 4));
        check(ring_tick == tick_at(n, 20), "R3", ring_tick, tick_at(n, 20));
        check(stage_tick == es, "R4 R9", stage_tick, es);
        check(inc_req == (es[INC-1] && pw), "R5", inc_req, es[INC-1] && pw);
        check(power_en == pw, "R6 R7", power_en, pw);
        check(wake_pulse == (m_state == 1 && last), "R7", wake_pulse, m_state == 1 && last);
    endtask

    // advance the model across one clock edge using the applied stby_allow
    task automatic step_model(bit last);
        case (m_state)
            0: if (stby_allow) m_state = 1;
            1: if (last) begin m_state = 2; m_hold = HOLD - 1; end
            default: begin
                if (m_hold == 0) m_state = stby_allow ? 1 : 0;   // R8
                else m_hold--;
            end
        endcase
    endtask

    // mode 0: stby low, 1: stby high, 2: random bursts
    task automatic run(int cycles, int mode);
        for (int i = 0; i < cycles; i++) begin
            logic [NS-1:0] es;
            check_cycle();
            es = exp_stages(n);
            if (mode == 0)      stby_allow = 1'b0;
            else if (mode == 1) stby_allow = 1'b1;
            else if (($urandom % 300) == 0) stby_allow = ~stby_allow;
            step_model(es[NS-1]);
            @(negedge clk); #1;
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst = 1'b1;
        stby_allow = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // reset state
        check(phase == 4'b0001, "R1 reset", phase, 4'b0001);
        check(power_en == 1'b1, "R6 reset", power_en, 1);
        check(stage_tick == '0 && !ring_tick && !mstr_tick, "R3 R4 reset",
              {stage_tick, ring_tick, mstr_tick}, 0);
        check(!inc_req && !wake_pulse, "R5 R7 reset", {inc_req, wake_pulse}, 0);
        rst = 1'b0;
        n = 0; m_state = 0; m_hold = 0;
    endtask

    initial begin
        void'($urandom(32'd20250117));
        do_reset();
        run(3000, 0);                 // free running, powered
        run(4000, 1);                 // sleep and repeated wake, stays asleep
        run(200, 0);                  // release: next wake resumes
        run(2000, 0);
        do_reset();                   // reset mid-activity
        run(1500, 1);
        run(20000, 2);                // random standby pattern
        run(2600, 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule